// File: doc/BRIEF.md
# Periodic Compare Timer Channel

This block is one channel of a periodic timer. A free-running prescaler divides the system clock into one-cycle enable pulses. A two-bit clock-select field picks one of four division ratios. While a run input is high, each selected pulse advances a 16-bit up-counter. When the counter holds the same value as a 16-bit compare register at a count pulse, the counter returns to zero on that pulse and a sticky match flag is raised. The result is a periodic event with a period of (compare + 1) prescaled ticks.

Software reaches three 16-bit registers over a simple synchronous register bus. Write strobes act on the clock edge. Read data depends only on the address and is combinational. The control/status register holds the match flag, an interrupt enable and the clock select. Software clears the flag with a two-step handshake: it reads the register while the flag is 1, then writes the register with the flag bit at 0. If a new match lands in the same cycle as that clearing write, the flag stays set. The interrupt line is high while the flag and the enable are both 1.

Top module: `match_timer`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x0000, the counter (address 1) reads 0x0000, the compare register (address 2) reads 0xFFFF, and `irq` is low. Address 3 always reads 0x0000.
- R2: In the control/status register, bit 6 (interrupt enable) and bits 1..0 (clock select) are read/write. Bits 15..8 and 5..2 always read 0, and writes to them are ignored.
- R3: With clock select 00/01/10/11, the counter advances once every 8/32/128/512 system cycles while `count_run` is high. While `count_run` is low, the counter holds its value.
- R4: When the counter equals the compare value at a count pulse, the counter becomes 0 on that pulse and the match flag (bit 7) reads 1 from then on.
- R5: Writing 1 to bit 7 never sets the flag. Writing 0 to bit 7 with no earlier read that returned bit 7 = 1 leaves the flag set.
- R6: A write with bit 7 = 0 clears the flag when it follows a read of address 0 that returned bit 7 = 1. Any write to address 0 consumes that earlier read.
- R7: If a match occurs in the same cycle as a clearing write, the flag stays 1.
- R8: `irq` is high exactly while the flag and the interrupt enable are both 1.
- R9: Asserting `standby` for one cycle returns the control/status register to 0x0000. This clears the flag, the enable and the clock select.
- R10: A bus write to the counter in a cycle that also has a count pulse loads the written value, and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Low-power request; clears the control/status register |
| count_run | input | 1 | Counter advances only while high |
| bus_addr | input | 2 | Register address: 0 control/status, 1 counter, 2 compare |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag-clear handshake) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Compare match interrupt request |

## Verification
The bench uses the default parameters: a base division of 8 and a step of 4 per select code, which gives the 8/32/128/512 ratios. Even the slowest ratio fits in a short run at these values, so every select code is measured exactly from one counter change to the next. A small compare value makes matches repeat every few ticks. The bench can therefore count cycles from a counter change and put a clearing write or a counter write on exactly the cycle that carries a count pulse. That exact timing is what reaches the set-over-clear and write-over-increment cases.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int REG_W     = 16;
    localparam int ADDR_W    = 2;
    localparam int FLAG_POS  = 7;
    localparam int IEN_POS   = 6;
    localparam int NUM_SEL   = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL    = 2'd0,
        RA_COUNT   = 2'd1,
        RA_COMPARE = 2'd2,
        RA_NONE    = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        SEL_SLOWEST_NOT = 2'd0,
        SEL_DIV_B       = 2'd1,
        SEL_DIV_C       = 2'd2,
        SEL_DIV_D       = 2'd3
    } clk_sel_e;

    typedef struct packed {
        logic     flag;
        logic     irq_en;
        clk_sel_e sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{flag: 1'b0, irq_en: 1'b0, sel: SEL_SLOWEST_NOT};

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] v;
        v           = '0;
        v[FLAG_POS] = c.flag;
        v[IEN_POS]  = c.irq_en;
        v[1:0]      = c.sel;
        return v;
    endfunction

endpackage

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler #(
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 2,
    parameter int NSEL      = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NSEL)-1:0] sel,
    output logic                    tick
);
    localparam int PW = BASE_LOG2 + (NSEL - 1) * STEP_LOG2;

    logic [PW-1:0]   div_q;
    logic [NSEL-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    for (genvar g = 0; g < NSEL; g++) begin : g_tap
        localparam int L = BASE_LOG2 + g * STEP_LOG2;
        assign taps[g] = &div_q[L-1:0];
    end

    assign tick = taps[sel];

    AST_TAP_NESTED: assert property (@(posedge clk) disable iff (rst)
        taps[NSEL-1] |-> taps[0]); // R3

endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run,
    input  logic          cnt_wr,
    input  logic          cmp_wr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] count_q,
    output logic [DW-1:0] compare_q,
    output logic          match_evt
);
    logic step;
    logic hit;

    assign step      = tick && run;
    assign hit       = (count_q == compare_q);
    assign match_evt = step && hit && !cnt_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            count_q <= wr_data;
        end else if (step) begin
            count_q <= hit ? '0 : count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         compare_q <= '1;
        else if (cmp_wr) compare_q <= wr_data;
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> (count_q == '0)); // R4

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count_q == $past(wr_data))); // R10

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> (count_q == $past(count_q))); // R3

endmodule

// File: rtl/mtmr_ctrl.sv
module mtmr_ctrl
    import mtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             standby,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             match_evt,
    output ctrl_t            ctrl_q,
    output logic             armed_q
);
    logic clr_req;

    assign clr_req = wr_en && armed_q && !wr_data[FLAG_POS];

    always_ff @(posedge clk) begin
        if (rst || standby)              armed_q <= 1'b0;
        else if (wr_en)                  armed_q <= 1'b0;
        else if (rd_en && ctrl_q.flag)   armed_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            if (match_evt)    ctrl_q.flag <= 1'b1;
            else if (clr_req) ctrl_q.flag <= 1'b0;
            if (wr_en) begin
                ctrl_q.irq_en <= wr_data[IEN_POS];
                ctrl_q.sel    <= clk_sel_e'(wr_data[1:0]);
            end
        end
    end

    AST_FLAG_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.flag) |-> $past(match_evt)); // R5

    AST_FLAG_FALL_SRC: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.flag) |-> ($past(armed_q) && $past(wr_en)) || $past(standby)); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (match_evt && !standby) |=> ctrl_q.flag); // R7

endmodule

// File: rtl/match_timer.sv
module match_timer
    import mtmr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              count_run,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t       ctrl_q;
    logic        armed_q;
    logic        tick;
    logic        match_evt;
    logic        wr_ctrl, wr_cnt, wr_cmp, rd_ctrl;
    logic [DATA_W-1:0] count_q, compare_q;

    assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
    assign wr_cnt  = bus_wr && (bus_addr == RA_COUNT);
    assign wr_cmp  = bus_wr && (bus_addr == RA_COMPARE);
    assign rd_ctrl = bus_rd && (bus_addr == RA_CTRL);

    mtmr_prescaler #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .NSEL      (NUM_SEL)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctrl_q.sel),
        .tick (tick)
    );

    mtmr_counter #(.DW(DATA_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .run       (count_run),
        .cnt_wr    (wr_cnt),
        .cmp_wr    (wr_cmp),
        .wr_data   (bus_wdata),
        .count_q   (count_q),
        .compare_q (compare_q),
        .match_evt (match_evt)
    );

    mtmr_ctrl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .standby   (standby),
        .wr_en     (wr_ctrl),
        .rd_en     (rd_ctrl),
        .wr_data   (bus_wdata[REG_W-1:0]),
        .match_evt (match_evt),
        .ctrl_q    (ctrl_q),
        .armed_q   (armed_q)
    );

    always_comb begin
        unique case (bus_addr)
            RA_CTRL:    bus_rdata = DATA_W'(pack_ctrl(ctrl_q));
            RA_COUNT:   bus_rdata = count_q;
            RA_COMPARE: bus_rdata = compare_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = ctrl_q.flag && ctrl_q.irq_en;

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == RA_CTRL) |-> (bus_rdata[15:8] == 8'h00 && bus_rdata[5:2] == 4'h0)); // R2

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && !$past(wr_ctrl)) |-> $past(match_evt)); // R8

endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby = 1'b0;
    logic        count_run = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    match_timer u_dut (
        .clk(clk), .rst(rst), .standby(standby), .count_run(count_run),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {addr, write data, expected read-back}
    localparam logic [33:0] VEC [6] = '{
        {2'd0, 16'hFFFF, 16'h0043},  // R2 R5: reserved ignored, flag not set by 1
        {2'd0, 16'h0000, 16'h0000},  // R2
        {2'd2, 16'h1234, 16'h1234},
        {2'd1, 16'h00AB, 16'h00AB},
        {2'd0, 16'h0042, 16'h0042},  // R2
        {2'd3, 16'hBEEF, 16'h0000}   // R1 unused address
    };

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_count(input logic [15:0] val);
        logic [15:0] v;
        for (int i = 0; i < 5000; i++) begin
            peek(2'd1, v);
            if (v == val) return;
            @(negedge clk);
        end
    endtask

    task automatic wait_change();
        logic [15:0] p, v;
        peek(2'd1, p);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            peek(2'd1, v);
            if (v != p) return;
        end
    endtask

    task automatic measure(input int exp, input string tag);
        logic [15:0] p, v;
        int n;
        wait_change();
        peek(2'd1, p);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            n++;
            peek(2'd1, v);
            if (v != p) break;
        end
        chk(n == exp, tag, 16'(n), 16'(exp));
    endtask

    task automatic wait_flag();
        logic [15:0] v;
        for (int i = 0; i < 5000; i++) begin
            peek(2'd0, v);
            if (v[7]) return;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rd(2'd0, v); chk(v == 16'h0000, "R1 ctrl reset", v, 16'h0000);
        rd(2'd1, v); chk(v == 16'h0000, "R1 count reset", v, 16'h0000);
        rd(2'd2, v); chk(v == 16'hFFFF, "R1 compare reset", v, 16'hFFFF);
        chk(irq == 1'b0, "R1 irq reset", 16'(irq), 16'h0);

        // table walk: R2 R5 register access
        foreach (VEC[i]) begin
            wr(VEC[i][33:32], VEC[i][31:16]);
            rd(VEC[i][33:32], v);
            chk(v == VEC[i][15:0], "R2 vector readback", v, VEC[i][15:0]);
        end
        wr(2'd2, 16'hFFFF);

        // R3 periods for each select
        wr(2'd1, 16'h0000);
        count_run = 1'b1;
        wr(2'd0, 16'h0000); measure(8,   "R3 div sel0");
        wr(2'd0, 16'h0001); measure(32,  "R3 div sel1");
        wr(2'd0, 16'h0002); measure(128, "R3 div sel2");
        wr(2'd0, 16'h0003); measure(512, "R3 div sel3");

        // R3 hold while stopped
        wr(2'd0, 16'h0000);
        count_run = 1'b0;
        peek(2'd1, v);
        begin
            logic [15:0] w;
            repeat (40) @(negedge clk);
            peek(2'd1, w);
            chk(w == v, "R3 hold when stopped", w, v);
        end

        // R10 write wins over increment on a tick cycle
        count_run = 1'b1;
        wait_change();
        repeat (7) @(negedge clk);
        wr(2'd1, 16'h0100);
        peek(2'd1, v);
        chk(v == 16'h0100, "R10 write wins", v, 16'h0100);

        // R4 wrap and flag
        standby = 1'b1; @(negedge clk); standby = 1'b0;
        wr(2'd2, 16'h0002);
        wr(2'd1, 16'h0000);
        wait_count(16'h0002);
        wait_change();
        peek(2'd1, v); chk(v == 16'h0000, "R4 wrap to zero", v, 16'h0000);
        peek(2'd0, v); chk(v[7] == 1'b1, "R4 flag set at wrap", v, 16'h0080);

        // R5 clear without prior read-as-1 has no effect; R8 irq gating
        chk(irq == 1'b0, "R8 irq low when disabled", 16'(irq), 16'h0);
        wr(2'd0, 16'h0040);
        peek(2'd0, v); chk(v[7] == 1'b1, "R5 unarmed clear ignored", v, 16'h00C0);
        chk(irq == 1'b1, "R8 irq high flag and enable", 16'(irq), 16'h1);

        // R6 read then clear
        rd(2'd0, v);
        wr(2'd0, 16'h0040);
        peek(2'd0, v); chk(v[7] == 1'b0, "R6 armed clear", v, 16'h0040);
        chk(irq == 1'b0, "R8 irq low after clear", 16'(irq), 16'h0);

        // R7 set wins over same-cycle clear
        wr(2'd2, 16'h0001);
        wr(2'd1, 16'h0000);
        wait_flag();
        rd(2'd0, v);
        wait_count(16'h0000);
        wait_count(16'h0001);
        repeat (7) @(negedge clk);
        wr(2'd0, 16'h0040);
        peek(2'd0, v); chk(v[7] == 1'b1, "R7 set beats clear", v, 16'h00C0);
        peek(2'd1, v); chk(v == 16'h0000, "R4 periodic wrap", v, 16'h0000);

        // R6 write consumed the earlier read: another clear without read is ignored
        wr(2'd0, 16'h0040);
        peek(2'd0, v); chk(v[7] == 1'b1, "R6 read consumed by write", v, 16'h00C0);

        // R9 standby
        wr(2'd0, 16'h0043);
        standby = 1'b1; @(negedge clk); standby = 1'b0;
        rd(2'd0, v); chk(v == 16'h0000, "R9 standby clears ctrl", v, 16'h0000);
        chk(irq == 1'b0, "R9 irq low after standby", 16'(irq), 16'h0);

        done = 1;
        summary();
    end
endmodule